// File: doc/BRIEF.md
# Four-Phase Pattern Sequencer

This block steps through a fixed cycle of four 4-bit output patterns: 0001, 0011, 1100 and 1000, after which the cycle starts again. Each pattern is held for one clock cycle while stepping is enabled. It can drive a row of four lamps or the four coil drivers of a stepper motor, where each output bit switches one lamp or coil.

The machine is a Moore machine. Its only state is a 2-bit binary register that counts 00, 01, 10, 11 and then wraps to 00. Small gate equations compute both the next state and the four output bits from that register. No data input reaches the outputs. An advance enable lets the surrounding logic stop the sequence on its current pattern, and the state is brought out so that the current phase can be observed.

Top module: `stepseq_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 00 and the pattern becomes 0001 after that edge.
- R2: When `adv_en` is high and `rst` is low at a rising edge, the state steps 00 to 01 to 10 to 11 and then wraps back to 00.
- R3: The pattern is a fixed function of the state, with bit 3 = w, bit 2 = x, bit 1 = y and bit 0 = z. State 00 gives 0001, 01 gives 0011, 10 gives 1100 and 11 gives 1000.
- R4: When `adv_en` is low and `rst` is low at a rising edge, the state and the pattern keep their values.
- R5: Toggling `adv_en` between clock edges does not change `phase_out` or `state_out` within that cycle.
- R6: While `adv_en` stays high, each pattern lasts exactly one cycle, and the pattern four steps later equals the current pattern.
- R7: `rst` takes priority over `adv_en` when both are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; the state steps on each edge where it is high |
| phase_out | output | 4 | Pattern {w,x,y,z} |
| state_out | output | 2 | Current binary state |

## Verification
The assertions assume that `rst` is held high at the first clock edge, so the state is known from then on. They also assume that `adv_en` is a clean level when it is sampled at each rising edge. The bench meets both assumptions by asserting reset from time zero and by changing `adv_en` only on falling edges or halfway between edges. It runs long stretches of random enable values, mixed with directed runs of constant enable and a reset that arrives while the enable is high.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int STATE_W = 2;
  localparam int OUT_W   = 4;

  typedef logic [STATE_W-1:0] phase_t;
  typedef logic [OUT_W-1:0]   pattern_t;

  localparam phase_t PHASE_RESET = '0;

  // Next state, written as gate equations: n1 = s1 ^ s0, n0 = ~s0
  function automatic phase_t phase_next(input phase_t s);
    phase_t n;
    n[1] = s[1] ^ s[0];
    n[0] = ~s[0];
    return n;
  endfunction

  // Output decode {w,x,y,z}, driven by the state alone
  function automatic pattern_t phase_pattern(input phase_t s);
    pattern_t p;
    p[3] = s[1];
    p[2] = s[1] & ~s[0];
    p[1] = ~s[1] & s[0];
    p[0] = ~s[1];
    return p;
  endfunction
endpackage

// File: rtl/stepseq_next.sv
module stepseq_next
  import stepseq_pkg::*;
(
  input  phase_t cur_state,
  input  logic   adv_en,
  output phase_t nxt_state,
  output logic   step_taken
);
  phase_t stepped;

  always_comb begin
    stepped    = phase_next(cur_state);
    step_taken = adv_en;
    nxt_state  = adv_en ? stepped : cur_state;
  end
endmodule

// File: rtl/stepseq_reg.sv
module stepseq_reg
  import stepseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t nxt_state,
  input  logic   step_taken,
  output phase_t state_q
);
  always_ff @(posedge clk) begin
    if (rst) state_q <= PHASE_RESET;
    else     state_q <= nxt_state;
  end

  // R1 and R7: reset clears the state even when stepping is requested
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (state_q == PHASE_RESET));
  // R2: each enabled edge adds one to the state, modulo four
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (rst)
    step_taken |=> (state_q == phase_t'($past(state_q) + phase_t'(1))));
  // R4: the state holds when stepping is disabled
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !step_taken |=> $stable(state_q));
endmodule

// File: rtl/stepseq_decode.sv
module stepseq_decode
  import stepseq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  phase_t   state_q,
  output pattern_t pattern
);
  always_comb pattern = phase_pattern(state_q);

  // R3: w and z are always complements, and one or two bits are set
  a_r3_wz_opposite: assert property (@(posedge clk) disable iff (rst)
    pattern[3] != pattern[0]);
  a_r3_weight: assert property (@(posedge clk) disable iff (rst)
    ($countones(pattern) == 1) || ($countones(pattern) == 2));
  // R3: x and y are never set together
  a_r3_xy_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pattern[2] && pattern[1]));
endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_en,
  output logic [3:0] phase_out,
  output logic [1:0] state_out
);
  phase_t   nxt_state;
  phase_t   state_q;
  pattern_t pattern;
  logic     step_taken;

  stepseq_next u_next (
    .cur_state (state_q),
    .adv_en    (adv_en),
    .nxt_state (nxt_state),
    .step_taken(step_taken)
  );

  stepseq_reg u_reg (
    .clk       (clk),
    .rst       (rst),
    .nxt_state (nxt_state),
    .step_taken(step_taken),
    .state_q   (state_q)
  );

  stepseq_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .state_q(state_q),
    .pattern(pattern)
  );

  assign phase_out = pattern;
  assign state_out = state_q;

  // R6: an enabled step always changes the visible pattern
  a_r6_pattern_moves: assert property (@(posedge clk) disable iff (rst)
    step_taken |=> (phase_out != $past(phase_out)));
  // R4: a disabled edge leaves the visible pattern unchanged
  a_r4_pattern_holds: assert property (@(posedge clk) disable iff (rst)
    !step_taken |=> $stable(phase_out));
endmodule

// File: tb/stepseq_top_test.sv
module stepseq_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       adv_en = 1'b0;
  logic [3:0] phase_out;
  logic [1:0] state_out;

  int errors = 0;
  int checks = 0;
  int model  = 0;
  bit done   = 1'b0;

  stepseq_top uut (
    .clk(clk), .rst(rst), .adv_en(adv_en),
    .phase_out(phase_out), .state_out(state_out)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] exp_pat(input int s);
    case (s % 4)
      0: return 4'b0001;
      1: return 4'b0011;
      2: return 4'b1100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic check(input string req, input int s);
    checks++;
    if (state_out !== 2'(s) || phase_out !== exp_pat(s)) begin
      errors++;
      $display("FAIL %s: state=%b pat=%b expected state=%b pat=%b",
               req, state_out, phase_out, 2'(s), exp_pat(s));
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, and sample at the next falling edge
  task automatic cycle(input bit r, input bit en);
    rst = r; adv_en = en;
    @(negedge clk);
    if (r) model = 0;
    else if (en) model = (model + 1) % 4;
  endtask

  initial begin
    int seed;
    logic [3:0] snap_p;
    logic [1:0] snap_s;
    seed = $urandom(32'd2024);
    @(negedge clk);
    cycle(1'b1, 1'b0);
    check("R1", 0);
    // R2 R3 R6: a full lap with the enable held high
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1);
      check("R2", model);
      check("R6", model);
    end
    // R4: the enable held low
    cycle(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b0, 1'b0);
      check("R4", model);
    end
    // R7: reset arriving while the enable is high
    cycle(1'b0, 1'b1);
    cycle(1'b1, 1'b1);
    check("R7", 0);
    // R5: toggling the enable between edges
    for (int i = 0; i < 6; i++) begin
      cycle(1'b0, 1'b1);
      snap_p = phase_out; snap_s = state_out;
      #2 adv_en = ~adv_en;
      #1 adv_en = ~adv_en;
      checks++;
      if (phase_out !== snap_p || state_out !== snap_s) begin
        errors++;
        $display("FAIL R5: pat=%b state=%b expected pat=%b state=%b",
                 phase_out, state_out, snap_p, snap_s);
      end
      @(negedge clk);
      model = adv_en ? (model + 1) % 4 : model;
      check("R3", model);
    end
    // Random enables with an occasional reset
    for (int i = 0; i < 400; i++) begin
      cycle(($urandom % 50) == 0, $urandom % 2 == 1);
      check("R3", model);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule